// File: doc/BRIEF.md
# Downlink OFDMA Frame Timing Controller

This block is a free-running timing controller for a downlink radio frame built from OFDMA symbols. Once out of reset it counts through twenty slots. Each slot holds seven symbols, and each symbol is made of a cyclic prefix followed by a 512-sample useful part. The first symbol of a slot has a longer prefix than the other six. Alongside the three position counters it produces registered Boolean control flags. These flags tell a downstream sample datapath when to emit prefix samples and when to emit useful samples. They also mark the symbols that carry primary or secondary synchronization sequences and the symbols that carry data.

The block also issues a one-clock start strobe to a transform engine a fixed number of clocks before each symbol begins, so the engine's pipeline is primed when the first sample arrives. The enable input freezes all counting. A synchronous reset returns the controller to the start of the frame.

A two-state machine with the states PREFIX and BODY follows the phase within a symbol:

- It moves from PREFIX to BODY on the clock that leaves the last prefix sample.
- It moves from BODY back to PREFIX on the clock that leaves the last useful sample. That same clock advances the symbol counter, and after symbol 6 it also advances the slot counter.
- Reset forces the PREFIX state.

Top module: `dl_frame_timer`

## Requirements
- R1: `slot_idx` counts from 0 to 19. It increments when symbol 6 of a slot ends, and it wraps from 19 to 0.
- R2: `sym_idx` counts from 0 to 6 within a slot. `samp_idx` counts from 0 to 551 in symbol 0 and from 0 to 547 in symbols 1 to 6, then returns to 0 and advances the symbol.
- R3: `cp_phase` is high while `samp_idx` is below 40 in symbol 0, or below 36 in symbols 1 to 6. `useful_phase` is high for the remaining samples. The two flags are never high together.
- R4: `pss_flag` is high throughout symbol 6 of slots 0 and 10, and is low at all other times.
- R5: `sss_flag` is high throughout symbol 5 of slots 0 and 10, and is low at all other times.
- R6: `data_flag` is high exactly when neither synchronization flag is high.
- R7: `fft_start` is high for one clock on each clock where `samp_idx` has just advanced to the symbol length minus 3. That is three enabled clocks before the next symbol's sample 0. Symbol 0 of slot 0 straight after reset therefore gets no strobe.
- R8: While `en` is low, all counters and flags hold their values and `fft_start` is low.
- R9: A synchronous `rst` sets every counter to 0 and `fft_start` to 0, with `cp_phase` = 1, `useful_phase` = 0, `pss_flag` = 0, `sss_flag` = 0 and `data_flag` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; counters hold when low |
| slot_idx | output | 5 | Slot index within the frame, 0..19 |
| sym_idx | output | 3 | Symbol index within the slot, 0..6 |
| samp_idx | output | 10 | Sample index within the symbol |
| cp_phase | output | 1 | Current sample belongs to the cyclic prefix |
| useful_phase | output | 1 | Current sample belongs to the useful part |
| pss_flag | output | 1 | Primary synchronization symbol |
| sss_flag | output | 1 | Secondary synchronization symbol |
| data_flag | output | 1 | Data symbol |
| fft_start | output | 1 | Early transform start strobe |

## Verification
The bench runs one full frame and goes past the slot 19 to slot 0 wrap. Along the way it exercises both prefix lengths, both synchronization slots, and the data slots between them.

Short stretches of low enable are sprinkled through the run. These separate a controller that truly freezes from one that only gates its counters while the strobe or the flags keep moving.

A reset in the middle of a frame checks that recovery starts cleanly from slot 0. Because no strobe is expected for that first symbol, the run also shows that the strobe is tied to the count position and not to a timer started at reset.

// File: rtl/dlft_pkg.sv
package dlft_pkg;
    typedef enum logic {
        ST_PREFIX = 1'b0,
        ST_BODY   = 1'b1
    } phase_t;
endpackage

// File: rtl/dlft_sample_fsm.sv
module dlft_sample_fsm
    import dlft_pkg::*;
#(
    parameter int SAMP_W     = 10,
    parameter int CP_FIRST   = 40,
    parameter int CP_OTHER   = 36,
    parameter int USEFUL_LEN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              first_sym,
    output logic [SAMP_W-1:0] samp_q,
    output logic [SAMP_W-1:0] samp_nxt,
    output phase_t            phase_nxt,
    output logic              sym_end
);
    localparam int LEN_FIRST = CP_FIRST + USEFUL_LEN;
    localparam int LEN_OTHER = CP_OTHER + USEFUL_LEN;

    phase_t            phase_q;
    logic [SAMP_W-1:0] cp_last;
    logic [SAMP_W-1:0] sym_last;

    always_comb begin
        cp_last  = first_sym ? SAMP_W'(CP_FIRST - 1)  : SAMP_W'(CP_OTHER - 1);
        sym_last = first_sym ? SAMP_W'(LEN_FIRST - 1) : SAMP_W'(LEN_OTHER - 1);
        sym_end  = en && (samp_q == sym_last);
    end

    // next-state logic of the prefix/body machine
    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            ST_PREFIX: if (en && samp_q == cp_last) phase_nxt = ST_BODY;
            ST_BODY:   if (sym_end)                 phase_nxt = ST_PREFIX;
        endcase
    end

    always_comb begin
        if (!en)          samp_nxt = samp_q;
        else if (sym_end) samp_nxt = '0;
        else              samp_nxt = samp_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_PREFIX;
            samp_q  <= '0;
        end else begin
            phase_q <= phase_nxt;
            samp_q  <= samp_nxt;
        end
    end
endmodule

// File: rtl/dlft_position.sv
module dlft_position #(
    parameter int NUM_SLOTS = 20,
    parameter int SYMS      = 7,
    parameter int SYM_W     = 3,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_end,
    output logic [SYM_W-1:0]  sym_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SYM_W-1:0]  sym_nxt,
    output logic [SLOT_W-1:0] slot_nxt
);
    logic slot_end;

    always_comb begin
        slot_end = sym_end && (sym_q == SYM_W'(SYMS - 1));
        sym_nxt  = sym_q;
        slot_nxt = slot_q;
        if (sym_end) sym_nxt = slot_end ? '0 : sym_q + 1'b1;
        if (slot_end) slot_nxt = (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= '0;
            slot_q <= '0;
        end else begin
            sym_q  <= sym_nxt;
            slot_q <= slot_nxt;
        end
    end
endmodule

// File: rtl/dlft_flags.sv
module dlft_flags
    import dlft_pkg::*;
#(
    parameter int SAMP_W     = 10,
    parameter int SYM_W      = 3,
    parameter int SLOT_W     = 5,
    parameter int CP_FIRST   = 40,
    parameter int CP_OTHER   = 36,
    parameter int USEFUL_LEN = 512,
    parameter int LEAD       = 3,
    parameter int SYNC_SLOTS = 2,
    parameter int SYNC_SLOT_STEP = 10,
    parameter int PSS_SYM    = 6,
    parameter int SSS_SYM    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  phase_t            phase_nxt,
    input  logic [SAMP_W-1:0] samp_nxt,
    input  logic [SYM_W-1:0]  sym_nxt,
    input  logic [SLOT_W-1:0] slot_nxt,
    output logic              cp_phase,
    output logic              useful_phase,
    output logic              pss_flag,
    output logic              sss_flag,
    output logic              data_flag,
    output logic              fft_start
);
    logic [SYNC_SLOTS-1:0] slot_hit;
    logic                  sync_slot;
    logic                  pss_n, sss_n, start_n;
    logic [SAMP_W-1:0]     start_pos;

    // one comparator per synchronization slot
    for (genvar g = 0; g < SYNC_SLOTS; g++) begin : g_sync
        assign slot_hit[g] = (slot_nxt == SLOT_W'(g * SYNC_SLOT_STEP));
    end

    always_comb begin
        sync_slot = |slot_hit;
        pss_n     = sync_slot && (sym_nxt == SYM_W'(PSS_SYM));
        sss_n     = sync_slot && (sym_nxt == SYM_W'(SSS_SYM));
        start_pos = (sym_nxt == '0) ? SAMP_W'(CP_FIRST + USEFUL_LEN - LEAD)
                                    : SAMP_W'(CP_OTHER + USEFUL_LEN - LEAD);
        start_n   = en && (samp_nxt == start_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_phase     <= 1'b1;
            useful_phase <= 1'b0;
            pss_flag     <= 1'b0;
            sss_flag     <= 1'b0;
            data_flag    <= 1'b1;
            fft_start    <= 1'b0;
        end else begin
            cp_phase     <= (phase_nxt == ST_PREFIX);
            useful_phase <= (phase_nxt == ST_BODY);
            pss_flag     <= pss_n;
            sss_flag     <= sss_n;
            data_flag    <= !(pss_n || sss_n);
            fft_start    <= start_n;
        end
    end
endmodule

// File: rtl/dl_frame_timer.sv
module dl_frame_timer
    import dlft_pkg::*;
#(
    parameter int NUM_SLOTS  = 20,
    parameter int SYMS       = 7,
    parameter int CP_FIRST   = 40,
    parameter int CP_OTHER   = 36,
    parameter int USEFUL_LEN = 512,
    parameter int LEAD       = 3,
    parameter int SYNC_SLOTS = 2,
    parameter int PSS_SYM    = 6,
    parameter int SSS_SYM    = 5,
    localparam int SAMP_W    = $clog2(CP_FIRST + USEFUL_LEN),
    localparam int SYM_W     = $clog2(SYMS),
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int SYNC_STEP = NUM_SLOTS / SYNC_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [SYM_W-1:0]  sym_idx,
    output logic [SAMP_W-1:0] samp_idx,
    output logic              cp_phase,
    output logic              useful_phase,
    output logic              pss_flag,
    output logic              sss_flag,
    output logic              data_flag,
    output logic              fft_start
);
    logic [SAMP_W-1:0] samp_nxt;
    logic [SYM_W-1:0]  sym_nxt;
    logic [SLOT_W-1:0] slot_nxt;
    phase_t            phase_nxt;
    logic              sym_end;

    dlft_sample_fsm #(
        .SAMP_W(SAMP_W), .CP_FIRST(CP_FIRST), .CP_OTHER(CP_OTHER), .USEFUL_LEN(USEFUL_LEN)
    ) u_samp (
        .clk(clk), .rst(rst), .en(en), .first_sym(sym_idx == '0),
        .samp_q(samp_idx), .samp_nxt(samp_nxt), .phase_nxt(phase_nxt), .sym_end(sym_end)
    );

    dlft_position #(
        .NUM_SLOTS(NUM_SLOTS), .SYMS(SYMS), .SYM_W(SYM_W), .SLOT_W(SLOT_W)
    ) u_pos (
        .clk(clk), .rst(rst), .sym_end(sym_end),
        .sym_q(sym_idx), .slot_q(slot_idx), .sym_nxt(sym_nxt), .slot_nxt(slot_nxt)
    );

    dlft_flags #(
        .SAMP_W(SAMP_W), .SYM_W(SYM_W), .SLOT_W(SLOT_W),
        .CP_FIRST(CP_FIRST), .CP_OTHER(CP_OTHER), .USEFUL_LEN(USEFUL_LEN),
        .LEAD(LEAD), .SYNC_SLOTS(SYNC_SLOTS), .SYNC_SLOT_STEP(SYNC_STEP),
        .PSS_SYM(PSS_SYM), .SSS_SYM(SSS_SYM)
    ) u_flags (
        .clk(clk), .rst(rst), .en(en), .phase_nxt(phase_nxt), .samp_nxt(samp_nxt),
        .sym_nxt(sym_nxt), .slot_nxt(slot_nxt),
        .cp_phase(cp_phase), .useful_phase(useful_phase), .pss_flag(pss_flag),
        .sss_flag(sss_flag), .data_flag(data_flag), .fft_start(fft_start)
    );
endmodule

// File: rtl/dl_frame_timer_chk.sv
module dl_frame_timer_chk #(
    parameter int SLOT_W = 5,
    parameter int SYM_W  = 3,
    parameter int SAMP_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [SYM_W-1:0]  sym_idx,
    input logic [SAMP_W-1:0] samp_idx,
    input logic              cp_phase,
    input logic              useful_phase,
    input logic              pss_flag,
    input logic              sss_flag,
    input logic              data_flag,
    input logic              fft_start
);
    assert_slot_range_R1: assert property (@(posedge clk) disable iff (rst)
        slot_idx < SLOT_W'(20));

    assert_samp_range_R2: assert property (@(posedge clk) disable iff (rst)
        (sym_idx == '0) ? (samp_idx < SAMP_W'(552)) : (samp_idx < SAMP_W'(548)));

    assert_phase_excl_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({cp_phase, useful_phase}) == 1);

    assert_pss_place_R4: assert property (@(posedge clk) disable iff (rst)
        pss_flag |-> (sym_idx == SYM_W'(6)) && (slot_idx == '0 || slot_idx == SLOT_W'(10)));

    assert_sss_place_R5: assert property (@(posedge clk) disable iff (rst)
        sss_flag |-> (sym_idx == SYM_W'(5)) && (slot_idx == '0 || slot_idx == SLOT_W'(10)));

    assert_one_kind_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({pss_flag, sss_flag, data_flag}) == 1);

    assert_start_pos_R7: assert property (@(posedge clk) disable iff (rst)
        fft_start |-> samp_idx == ((sym_idx == '0) ? SAMP_W'(549) : SAMP_W'(545)));

    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        fft_start |=> !fft_start);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(samp_idx) && $stable(sym_idx) && $stable(slot_idx) && !fft_start);
endmodule

bind dl_frame_timer dl_frame_timer_chk #(
    .SLOT_W(SLOT_W), .SYM_W(SYM_W), .SAMP_W(SAMP_W)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .slot_idx(slot_idx), .sym_idx(sym_idx),
    .samp_idx(samp_idx), .cp_phase(cp_phase), .useful_phase(useful_phase),
    .pss_flag(pss_flag), .sss_flag(sss_flag), .data_flag(data_flag), .fft_start(fft_start)
);

// File: tb/sim_dl_frame_timer.sv
module sim_dl_frame_timer;
    typedef struct packed {
        logic [4:0] slot;
        logic [2:0] sym;
        logic [9:0] samp;
        logic       cp, useful, pss, sss, data, start;
        logic       is_rst;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [4:0] slot_idx;
    logic [2:0] sym_idx;
    logic [9:0] samp_idx;
    logic       cp_phase, useful_phase, pss_flag, sss_flag, data_flag, fft_start;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    exp_t q[$];

    int mslot = 0, msym = 0, msamp = 0;

    always #10 clk = ~clk;

    dl_frame_timer u0 (
        .clk(clk), .rst(rst), .en(en), .slot_idx(slot_idx), .sym_idx(sym_idx),
        .samp_idx(samp_idx), .cp_phase(cp_phase), .useful_phase(useful_phase),
        .pss_flag(pss_flag), .sss_flag(sss_flag), .data_flag(data_flag),
        .fft_start(fft_start)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (slot %0d sym %0d samp %0d)",
                     tag, act, exp, slot_idx, sym_idx, samp_idx);
        end
    endtask

    function automatic int sym_len(input int s);
        return (s == 0) ? 552 : 548;
    endfunction

    // driver: applies one clock of stimulus and pushes what the outputs must show after that edge
    task automatic step(input bit r, input bit e);
        exp_t x;
        @(negedge clk);
        rst = r;
        en  = e;
        x.start = 1'b0;
        if (r) begin
            mslot = 0; msym = 0; msamp = 0;
        end else if (e) begin
            msamp++;
            if (msamp == sym_len(msym)) begin
                msamp = 0;
                msym++;
                if (msym == 7) begin
                    msym = 0;
                    mslot = (mslot == 19) ? 0 : mslot + 1;
                end
            end
            x.start = (msamp == sym_len(msym) - 3);
        end
        x.slot   = 5'(mslot);
        x.sym    = 3'(msym);
        x.samp   = 10'(msamp);
        x.cp     = (msamp < ((msym == 0) ? 40 : 36));
        x.useful = !x.cp;
        x.pss    = (mslot == 0 || mslot == 10) && msym == 6;
        x.sss    = (mslot == 0 || mslot == 10) && msym == 5;
        x.data   = !(x.pss || x.sss);
        x.is_rst = r;
        q.push_back(x);
    endtask

    // monitor: compares shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                if (x.is_rst) begin
                    chk("R9 reset slot", slot_idx, 0);
                    chk("R9 reset sym", sym_idx, 0);
                    chk("R9 reset samp", samp_idx, 0);
                    chk("R9 reset cp", cp_phase, 1);
                    chk("R9 reset data", data_flag, 1);
                    chk("R9 reset start", fft_start, 0);
                end
                chk("R1 slot", slot_idx, x.slot);
                chk("R2 sym", sym_idx, x.sym);
                chk("R2 samp", samp_idx, x.samp);
                chk("R3 cp_phase", cp_phase, x.cp);
                chk("R3 useful_phase", useful_phase, x.useful);
                chk("R4 pss_flag", pss_flag, x.pss);
                chk("R5 sss_flag", sss_flag, x.sss);
                chk("R6 data_flag", data_flag, x.data);
                chk("R7 fft_start", fft_start, x.start);
                if (!en) chk("R8 start low while held", fft_start, 0);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        // R2/R3: a few enable-low clocks inside the first prefix
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // full frame plus slot 19 to 0 wrap (R1), with periodic holds (R8)
        for (int i = 0; i < 79000; i++) step(1'b0, (i % 1000) >= 2);
        // hold straddling a strobe position (R7, R8)
        for (int i = 0; i < 600; i++) step(1'b0, (i % 7) != 3);
        // mid-frame reset and recovery (R9)
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 1200; i++) step(1'b0, 1'b1);
        @(posedge clk);
        #5;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule